// File: doc/BRIEF.md
# Configuration Access Address Filter

This block sits on the configuration path of a root-complex bridge. Each incoming configuration request names a bus, a device/function pair and a register offset. The block packs these three fields into one flat offset inside the configuration memory window. It also decides whether the access may be issued at all.

An access is suppressed in three cases. The first is an access to the root bus that names any device/function other than zero, since only the bridge itself lives there. The second is an access to any other bus while the link is not in its active L0 state. The third is an access whose register offset is not dword aligned. A suppressed read completes with all ones, and a suppressed write completes without touching the window.

The root bus number is held in a small register that reset clears to zero and a one-cycle load strobe updates. The link state comes from a status word supplied by the link controller.

Top module: `cfg_addr_filter`

## Requirements
- R1: For an issued access, `mem_addr` equals `bus << 20 | devfn << 12 | reg`, which is the three request fields concatenated with the bus in bits 27:20, the device/function in bits 19:12 and the register offset in bits 11:0.
- R2: A request whose bus equals the root bus number and whose device/function is non-zero is blocked (`rsp_blocked` = 1).
- R3: A request to the root bus with device/function 0 and an aligned offset is issued whatever the link state.
- R4: A request to any bus other than the root bus is issued only when bit 4 (value 0x10) of `link_status` is 1; the other bits of `link_status` have no effect.
- R5: A blocked read responds with `rsp_rdata` = 0xFFFFFFFF and leaves `mem_en` low.
- R6: A blocked write leaves `mem_en` and `mem_we` low, so nothing reaches the window.
- R7: An issued read returns `mem_rdata` on `rsp_rdata`. An issued write drives `mem_we` high with the request's write data on `mem_wdata`.
- R8: Every cycle with `req_valid` high produces exactly one `rsp_valid` cycle on the next clock. A cycle without a request produces no response on the next clock.
- R9: A request whose register offset has either of bits 1:0 set is blocked.
- R10: The root bus number is 0 after reset. While `root_load` is high it takes `root_bus_in` at the clock edge, and that value applies from the next request onward.
- R11: During and just after reset, `rsp_valid`, `mem_en` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_load | input | 1 | Load strobe for the root bus register |
| root_bus_in | input | 8 | New root bus number |
| link_status | input | 32 | Link controller status word; bit 4 marks L0 |
| req_valid | input | 1 | Configuration request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_reg | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| mem_en | output | 1 | Window access strobe |
| mem_we | output | 1 | Window write enable |
| mem_addr | output | 28 | Flat offset into the window |
| mem_wdata | output | 32 | Write data to the window |
| mem_rdata | input | 32 | Read data from the window, same cycle |
| rsp_valid | output | 1 | Response present |
| rsp_blocked | output | 1 | Request was suppressed |
| rsp_rdata | output | 32 | Read response data |

## Verification
The hardest case to reach is the interaction between a moving root bus number and the link state. Bus 0 is ordinary only after the root register has been moved away from it, and a non-root bus behaves like the root bus only when it has been loaded as root. The stimulus therefore repeats full bus sweeps under two root settings, each with the link both up and down. The link-down case drives every status bit except bit 4, so that a design decoding the wrong bit is exposed. The register offset is swept through all 4096 values to reach every misaligned pattern.

// File: rtl/cfg_addr_filter.sv
`timescale 1ns/1ps
module cfg_addr_filter #(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int REG_W    = 12,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 32,
  parameter int LINK_BIT = 4,
  localparam int DEVFN_SH = REG_W,
  localparam int BUS_SH   = REG_W + DEVFN_W,
  localparam int OFF_W    = BUS_SH + BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_load,
  input  logic [BUS_W-1:0]  root_bus_in,
  input  logic [STAT_W-1:0] link_status,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [OFF_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_blocked,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [BUS_W-1:0] root_q;
  logic             wr_q;
  logic             on_root, link_up, misaligned, reject;
  logic             unused_stat;

  assign unused_stat = ^link_status;
  assign on_root     = (req_bus == root_q);
  assign link_up     = link_status[LINK_BIT];
  assign misaligned  = |req_reg[1:0];
  assign reject      = misaligned | (on_root ? (req_devfn != '0) : !link_up);

  always_ff @(posedge clk) begin
    if (!rst_n) root_q <= '0;
    else if (root_load) root_q <= root_bus_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_blocked <= 1'b0;
      wr_q        <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_blocked <= reject;
        wr_q        <= req_write;
        mem_addr    <= (OFF_W'(req_bus) << BUS_SH) | (OFF_W'(req_devfn) << DEVFN_SH) | OFF_W'(req_reg);
        mem_wdata   <= req_wdata;
      end
    end
  end

  assign mem_en    = rsp_valid & ~rsp_blocked;
  assign mem_we    = mem_en & wr_q;
  assign rsp_rdata = rsp_blocked ? '1 : mem_rdata;

  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mem_addr == {$past(req_bus), $past(req_devfn), $past(req_reg)});
  p_root_devfn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !root_load && req_bus == root_q && req_devfn != '0 |=> rsp_blocked);
  p_link_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_bus != root_q && !link_status[LINK_BIT] |=> rsp_blocked && !mem_en);
  p_blocked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_blocked |-> rsp_rdata == '1 && !mem_en);
  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en && rsp_valid);
  p_one_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (|req_reg[1:0]) |=> rsp_blocked);

endmodule

// File: tb/cfg_addr_filter_test.sv
`timescale 1ns/1ps
module cfg_addr_filter_test;
  logic        clk = 0, rst_n = 0;
  logic        root_load = 0;
  logic [7:0]  root_bus_in = 0;
  logic [31:0] link_status = 0;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_bus = 0, req_devfn = 0;
  logic [11:0] req_reg = 0;
  logic [31:0] req_wdata = 0;
  logic        mem_en, mem_we, rsp_valid, rsp_blocked;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, rsp_rdata;
  int checks = 0, fails = 0;
  logic [7:0] root_model = 0;

  always #2 clk = ~clk;
  assign mem_rdata = {4'h5, mem_addr};

  cfg_addr_filter uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] b, input logic [7:0] df, input logic [11:0] r,
                        input bit wr, input bit link);
    bit blk;
    logic [27:0] off;
    logic [31:0] wd;
    wd = {b, df, 4'h0, r} ^ 32'h3C3C_0F0F;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bus = b; req_devfn = df; req_reg = r; req_wdata = wd;
    link_status = link ? 32'h0000_0010 : 32'hFFFF_FFEF;
    @(negedge clk);
    req_valid = 0;
    blk = (r[1:0] != 0) || ((b == root_model) ? (df != 0) : !link);
    off = {b, df, r};
    chk(rsp_valid == 1, "R8 response", rsp_valid, 1);
    chk(rsp_blocked == blk, (r[1:0] != 0) ? "R9 misaligned" :
        (b == root_model) ? ((df != 0) ? "R2 root devfn" : "R3 root dev0") : "R4 link gate",
        rsp_blocked, blk);
    if (blk) begin
      if (wr) chk(!mem_en && !mem_we, "R6 blocked write", {mem_en, mem_we}, 0);
      else chk(rsp_rdata == 32'hFFFF_FFFF && !mem_en, "R5 blocked read", rsp_rdata, 32'hFFFF_FFFF);
    end else begin
      chk(mem_en && mem_addr == off, "R1 offset", mem_addr, off);
      if (wr) chk(mem_we && mem_wdata == wd, "R7 write issue", mem_wdata, wd);
      else chk(!mem_we && rsp_rdata == {4'h5, off}, "R7 read data", rsp_rdata, {4'h5, off});
    end
  endtask

  task automatic load_root(input logic [7:0] v);
    @(negedge clk);
    root_load = 1; root_bus_in = v;
    @(negedge clk);
    root_load = 0;
    root_model = v;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_en && !mem_we, "R11 reset outputs", {rsp_valid, mem_en, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !mem_en, "R11 after reset", {rsp_valid, mem_en}, 0);
    // R10: reset root is bus 0, so bus 0 devfn 1 is blocked even with link up
    access(8'd0, 8'd1, 12'h000, 0, 1);
    access(8'd0, 8'd0, 12'h004, 0, 0);
    foreach (root_model[i]) begin end
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) load_root(8'h37); // R10 load
      for (int b = 0; b < 256; b++)
        for (int k = 0; k < 4; k++)
          for (int l = 0; l < 2; l++) begin
            logic [7:0] dfs [4];
            dfs = '{8'd0, 8'd1, 8'd8, 8'd255};
            access(b[7:0], dfs[k], {b[5:0], 6'b0} ^ {k[1:0], 10'h0}, (b + k) % 3 == 0, l[0]);
          end
    end
    for (int r = 0; r < 4096; r++) access(8'h37, 8'd0, r[11:0], r[4], r[5]);
    // R8: idle cycle yields no response
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R8 no request", rsp_valid, 0);
    load_root(8'h00);
    access(8'h37, 8'd2, 12'h010, 0, 0);
    access(8'h00, 8'd0, 12'hFFC, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule